// File: doc/BRIEF.md
# SIMD Processing Element Grid

This block is a four-by-four grid of 16-bit processing elements driven by one shared instruction stream. Every element holds two 16-bit operand registers, called A and B, and a 48-bit result register P. On each accepted instruction all sixteen elements act together. They add or multiply their operands into P, or accumulate A into P. They can also move data to a neighbour over an eight-direction mesh.

A host loads the operand registers in parallel, issues one instruction at a time with a valid strobe, and waits for the done pulse. The low 16 bits of every P register are always visible on a read port. Two composite instructions reduce the grid. A row reduction collects each row's sum in its last column. A column reduction collects each column's sum in its last row. Issuing both in turn leaves the whole-grid total in the bottom-right element. A latch instruction takes a streaming sample vector into the top row. Repeated latch, shift-right and row-reduction steps therefore form a streaming FIR.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, every A, B and P register is zero and done is low.
- R2: Opcode 1 (load) writes A and B of element (r,c) from bits [16*(4r+c) +: 16] of ld_a and ld_b. P is left unchanged.
- R3: Opcode 3 sets P to sext(A)+sext(B), and opcode 4 sets P to the signed product A*B, both 48 bits wide. Bits [16*(4r+c) +: 16] of out_p show P[15:0] of element (r,c).
- R4: Opcode 5 sets P to P+sext(A), modulo 2^48.
- R5: Opcode 6 (shift) writes P[15:0] of each element into A of the element one step away in direction instr_dir. The direction codes are 0 up, 1 down, 2 right, 3 left, 4 up-right, 5 up-left, 6 down-right and 7 down-left. An element with no source inside the grid receives zero, and nothing wraps around.
- R6: Opcode 7 moves each A into the neighbour's A, and opcode 8 moves each B into the neighbour's B. Both use the direction codes and the edge-zero rule of R5.
- R7: All elements update on the same edge from the values their neighbours held before that edge.
- R8: Opcode 9 (row reduction) takes 6 cycles. Its first step shifts right, each later move relays A right, and each move is followed by an accumulate. Afterwards P of element (r,3) equals its prior P plus sext(P[15:0]) of elements (r,0..2). done stays low until the final step and is high in the cycle after it.
- R9: Opcode 10 (column reduction) does the same downward and takes 6 cycles, leaving each column's total in row 3. Running it after a row reduction leaves the grid total in element (3,3).
- R10: An instruction presented while a reduction is running is ignored.
- R11: Opcode 2 (latch) writes stream_in[16*c +: 16] into A of element (0,c). No other register changes.
- R12: An accepted single-step instruction raises done for exactly the one cycle after its acceptance edge. Codes 0 and 11 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_op | input | 4 | Opcode |
| instr_dir | input | 3 | Mesh direction for moves |
| ld_a | input | 256 | Parallel load data for all A registers |
| ld_b | input | 256 | Parallel load data for all B registers |
| stream_in | input | 64 | Streaming samples for the top row |
| done | output | 1 | Instruction completion pulse |
| out_p | output | 256 | Low 16 bits of every P register |

## Verification
Two things can coincide in one cycle: a reduction sequencing its internal steps and a fresh instruction arriving on the valid input. The bench provokes this by holding an add instruction valid through every busy cycle of a row reduction, the final step included. It then judges the result by the values in the last column and by the timing of done. Had the stray add been accepted, P would have been overwritten or the step count restarted. The second overlap occurs when done from one instruction is high while the next instruction is accepted back-to-back. The bench checks it by issuing consecutive instructions on adjacent cycles and comparing every element against a bench-side model.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LOAD   = 4'd1,
    OP_LATCH  = 4'd2,
    OP_ADD    = 4'd3,
    OP_MUL    = 4'd4,
    OP_ACC    = 4'd5,
    OP_SHIFT  = 4'd6,
    OP_BYPA   = 4'd7,
    OP_BYPB   = 4'd8,
    OP_ROWADD = 4'd9,
    OP_COLADD = 4'd10
  } opcode_e;

  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_S  = 3'd1,
    DIR_E  = 3'd2,
    DIR_W  = 3'd3,
    DIR_NE = 3'd4,
    DIR_NW = 3'd5,
    DIR_SE = 3'd6,
    DIR_SW = 3'd7
  } dir_e;

  typedef enum logic [2:0] {
    PE_HOLD,
    PE_WR_A,
    PE_WR_B,
    PE_WR_AB,
    PE_ADD,
    PE_MUL,
    PE_ACC
  } pe_cmd_e;

  // Row delta of a move in direction d
  function automatic int dir_drow(input int d);
    case (d)
      0, 4, 5: return -1;
      1, 6, 7: return 1;
      default: return 0;
    endcase
  endfunction

  // Column delta of a move in direction d
  function automatic int dir_dcol(input int d);
    case (d)
      2, 4, 6: return 1;
      3, 5, 7: return -1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pe_cmd_e       cmd,
  input  logic [DW-1:0] wa_d,
  input  logic [DW-1:0] wb_d,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [AW-1:0] p_q
);

  logic                   a_en, b_en, p_en;
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0]          sa, sb, p_d;

  always_comb begin
    a_en = (cmd == PE_WR_A) || (cmd == PE_WR_AB);
    b_en = (cmd == PE_WR_B) || (cmd == PE_WR_AB);
    p_en = (cmd == PE_ADD) || (cmd == PE_MUL) || (cmd == PE_ACC);
    sa   = AW'($signed(a_q));
    sb   = AW'($signed(b_q));
    prod = $signed(a_q) * $signed(b_q);
    case (cmd)
      PE_ADD:  p_d = sa + sb;
      PE_MUL:  p_d = AW'(prod);
      PE_ACC:  p_d = p_q + sa;
      default: p_d = p_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= '0;
    end else begin
      if (a_en) a_q <= wa_d;
      if (b_en) b_q <= wb_d;
      if (p_en) p_q <= p_d;
    end
  end

  // R3: product lands in P one edge after the multiply command
  a_r3_mul_result: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == PE_MUL) |=> ($signed(p_q[2*DW-1:0]) == $past($signed(a_q)) * $past($signed(b_q))));

  // R12: a hold command leaves every register of the element untouched
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == PE_HOLD) |=> ($stable(a_q) && $stable(b_q) && $stable(p_q)));

endmodule

// File: rtl/simd_seq.sv
module simd_seq
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instr_valid,
  input  logic [3:0] instr_op,
  input  logic [2:0] instr_dir,
  output opcode_e    iss_op,
  output dir_e       iss_dir,
  output logic       done
);

  localparam int RSTEPS = 2 * (COLS - 1);
  localparam int CSTEPS = 2 * (ROWS - 1);
  localparam int MAXS   = (RSTEPS > CSTEPS) ? RSTEPS : CSTEPS;
  localparam int CW     = $clog2(MAXS + 1);
  localparam logic [CW-1:0] RLAST = CW'(RSTEPS - 1);
  localparam logic [CW-1:0] CLAST = CW'(CSTEPS - 1);

  opcode_e       op_in;
  logic [CW-1:0] cnt_q, cnt_d, step, last;
  logic          vert_q, vert_d, kind;
  logic          busy, accept, comp_new, comp_act, done_d;

  always_comb begin
    op_in    = opcode_e'(instr_op);
    busy     = (cnt_q != '0);
    accept   = instr_valid && !busy;
    comp_new = accept && ((op_in == OP_ROWADD) || (op_in == OP_COLADD));
    comp_act = busy || comp_new;
    step     = busy ? cnt_q : '0;
    kind     = busy ? vert_q : (op_in == OP_COLADD);
    last     = kind ? CLAST : RLAST;

    iss_op  = OP_NOP;
    iss_dir = dir_e'(instr_dir);
    if (comp_act) begin
      iss_dir = kind ? DIR_S : DIR_E;
      if (step[0])          iss_op = OP_ACC;
      else if (step == '0)  iss_op = OP_SHIFT;
      else                  iss_op = OP_BYPA;
    end else if (accept) begin
      iss_op = op_in;
    end

    cnt_d  = '0;
    vert_d = vert_q;
    if (comp_act) begin
      vert_d = kind;
      cnt_d  = (step == last) ? '0 : step + 1'b1;
    end
    done_d = (accept && !comp_new) || (comp_act && (step == last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      vert_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      vert_q <= vert_d;
      done   <= done_d;
    end
  end

  // R10: a valid strobe during a reduction does not restart or stall it
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && instr_valid && (cnt_q != last)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8: done follows the final step and the sequencer returns to idle
  a_r8_done_final: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt_q == last)) |=> (done && (cnt_q == '0)));

  // R8: no done while intermediate steps remain
  a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt_q != last)) |=> !done);

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 16,
  parameter int AW   = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     instr_valid,
  input  logic [3:0]               instr_op,
  input  logic [2:0]               instr_dir,
  input  logic [ROWS*COLS*DW-1:0]  ld_a,
  input  logic [ROWS*COLS*DW-1:0]  ld_b,
  input  logic [COLS*DW-1:0]       stream_in,
  output logic                     done,
  output logic [ROWS*COLS*DW-1:0]  out_p
);

  localparam int NDIR = 8;

  logic [1:0]    rst_sync;
  logic          rst_n_i;
  opcode_e       iss_op;
  dir_e          iss_dir;
  logic [DW-1:0] a_q [ROWS][COLS];
  logic [DW-1:0] b_q [ROWS][COLS];
  logic [AW-1:0] p_q [ROWS][COLS];

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  simd_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .instr_valid(instr_valid),
    .instr_op   (instr_op),
    .instr_dir  (instr_dir),
    .iss_op     (iss_op),
    .iss_dir    (iss_dir),
    .done       (done)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [DW-1:0] nb_p [NDIR];
      logic [DW-1:0] nb_a [NDIR];
      logic [DW-1:0] nb_b [NDIR];
      pe_cmd_e       cmd;
      logic [DW-1:0] wa, wb;

      // Mesh: source element sits one step against the move direction
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam int SR = r - dir_drow(d);
        localparam int SC = c - dir_dcol(d);
        if (SR >= 0 && SR < ROWS && SC >= 0 && SC < COLS) begin : g_in
          assign nb_p[d] = p_q[SR][SC][DW-1:0];
          assign nb_a[d] = a_q[SR][SC];
          assign nb_b[d] = b_q[SR][SC];
        end else begin : g_edge
          assign nb_p[d] = '0;
          assign nb_a[d] = '0;
          assign nb_b[d] = '0;
        end
      end

      always_comb begin
        cmd = PE_HOLD;
        wa  = ld_a[IDX*DW +: DW];
        wb  = ld_b[IDX*DW +: DW];
        case (iss_op)
          OP_LOAD:  cmd = PE_WR_AB;
          OP_LATCH: if (r == 0) begin
                      cmd = PE_WR_A;
                      wa  = stream_in[c*DW +: DW];
                    end
          OP_ADD:   cmd = PE_ADD;
          OP_MUL:   cmd = PE_MUL;
          OP_ACC:   cmd = PE_ACC;
          OP_SHIFT: begin cmd = PE_WR_A; wa = nb_p[iss_dir]; end
          OP_BYPA:  begin cmd = PE_WR_A; wa = nb_a[iss_dir]; end
          OP_BYPB:  begin cmd = PE_WR_B; wb = nb_b[iss_dir]; end
          default:  cmd = PE_HOLD;
        endcase
      end

      simd_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk  (clk),
        .rst_n(rst_n_i),
        .cmd  (cmd),
        .wa_d (wa),
        .wb_d (wb),
        .a_q  (a_q[r][c]),
        .b_q  (b_q[r][c]),
        .p_q  (p_q[r][c])
      );

      assign out_p[IDX*DW +: DW] = p_q[r][c][DW-1:0];

      if (c == 0) begin : g_left_edge
        // R5: left column has no source for a rightward shift, so it takes zero
        a_r5_edge_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
          (iss_op == OP_SHIFT && iss_dir == DIR_E) |=> (a_q[r][c] == '0));
      end
    end
  end

endmodule

// File: tb/tb_simd_pe_array.sv
module tb_simd_pe_array;
  localparam int R  = 4;
  localparam int C  = 4;
  localparam int DW = 16;
  localparam int N  = R * C;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            instr_valid;
  logic [3:0]      instr_op;
  logic [2:0]      instr_dir;
  logic [N*DW-1:0] ld_a, ld_b;
  logic [C*DW-1:0] stream_in;
  logic            done;
  logic [N*DW-1:0] out_p;

  always #2 clk = ~clk;

  simd_pe_array dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_dir(instr_dir), .ld_a(ld_a), .ld_b(ld_b), .stream_in(stream_in),
    .done(done), .out_p(out_p)
  );

  typedef struct { int idx; logic [15:0] exp; string req; } exp_t;
  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  // Bench-side model of the grid
  logic signed [47:0] mp [R][C];
  logic [15:0]        ma [R][C];
  logic [15:0]        mb [R][C];
  bit                 kp [R][C];
  bit                 ka [R][C];
  int dr [8] = '{-1, 1, 0, 0, -1, -1, 1, 1};
  int dc [8] = '{0, 0, 1, -1, 1, -1, 1, -1};

  function automatic logic [47:0] sx(input logic [15:0] v);
    return {{32{v[15]}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected items and compares against the read port
  initial begin
    exp_t e;
    forever begin
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      checks++;
      if (out_p[e.idx*DW +: DW] !== e.exp) begin
        fails++;
        $display("FAIL %s out_p[%0d] actual=%0h expected=%0h", e.req, e.idx,
                 out_p[e.idx*DW +: DW], e.exp);
      end
    end
  end

  task automatic push_all(input string req);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (kp[r][c]) begin
          exp_t e;
          e.idx = r * C + c; e.exp = mp[r][c][15:0]; e.req = req;
          exp_q.push_back(e);
        end
  endtask

  function automatic logic [15:0] va(input int e);
    return 16'(e * 37 - 200);
  endfunction
  function automatic logic [15:0] vb(input int e);
    return 16'(13 - e * 5);
  endfunction

  task automatic m_move(input int kind, input int d);
    logic [15:0] na [R][C];
    logic [15:0] nbv [R][C];
    bit          nk [R][C];
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        int sr = r - dr[d];
        int sc = c - dc[d];
        bit in = (sr >= 0 && sr < R && sc >= 0 && sc < C);
        na[r][c] = ma[r][c]; nbv[r][c] = mb[r][c]; nk[r][c] = ka[r][c];
        if (kind == 0) begin
          na[r][c] = in ? mp[sr][sc][15:0] : 16'h0; nk[r][c] = in ? kp[sr][sc] : 1'b1;
        end else if (kind == 1) begin
          na[r][c] = in ? ma[sr][sc] : 16'h0; nk[r][c] = in ? ka[sr][sc] : 1'b1;
        end else begin
          nbv[r][c] = in ? mb[sr][sc] : 16'h0;
        end
      end
    ma = na; mb = nbv; ka = nk;
  endtask

  task automatic m_apply(input logic [3:0] op, input int d);
    case (op)
      4'd1: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
              ma[r][c] = ld_a[(r*C+c)*DW +: DW]; mb[r][c] = ld_b[(r*C+c)*DW +: DW]; ka[r][c] = 1;
            end
      4'd2: for (int c = 0; c < C; c++) begin ma[0][c] = stream_in[c*DW +: DW]; ka[0][c] = 1; end
      4'd3: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
              mp[r][c] = sx(ma[r][c]) + sx(mb[r][c]); kp[r][c] = ka[r][c];
            end
      4'd4: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
              logic signed [31:0] pr;
              pr = $signed(ma[r][c]) * $signed(mb[r][c]);
              mp[r][c] = {{16{pr[31]}}, pr}; kp[r][c] = ka[r][c];
            end
      4'd5: for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
              mp[r][c] = mp[r][c] + sx(ma[r][c]); kp[r][c] = kp[r][c] && ka[r][c];
            end
      4'd6: m_move(0, d);
      4'd7: m_move(1, d);
      4'd8: m_move(2, d);
      4'd9: for (int r = 0; r < R; r++) begin
              logic signed [47:0] t = mp[r][C-1];
              bit k = 1;
              for (int c = 0; c < C - 1; c++) begin
                t = t + sx(mp[r][c][15:0]); k = k && kp[r][c]; kp[r][c] = 0;
              end
              mp[r][C-1] = t; kp[r][C-1] = k && kp[r][C-1];
              for (int c = 0; c < C; c++) ka[r][c] = 0;
            end
      4'd10: for (int c = 0; c < C; c++) begin
              logic signed [47:0] t = mp[R-1][c];
              bit k = 1;
              for (int r = 0; r < R - 1; r++) begin
                t = t + sx(mp[r][c][15:0]); k = k && kp[r][c]; kp[r][c] = 0;
              end
              mp[R-1][c] = t; kp[R-1][c] = k && kp[R-1][c];
              for (int r = 0; r < R; r++) ka[r][c] = 0;
            end
      default: ;
    endcase
  endtask

  // Driver: called at a negedge, returns at the negedge where done is expected
  task automatic issue(input logic [3:0] op, input logic [2:0] d, input string req, input bit jam);
    int steps = (op == 4'd9) ? 2 * (C - 1) : (op == 4'd10) ? 2 * (R - 1) : 1;
    instr_op = op; instr_dir = d; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = jam;
    if (jam) instr_op = 4'd3;
    for (int s = 1; s < steps; s++) begin
      chk(done == 1'b0, "R8", "done during reduction", done, 0);
      @(negedge clk);
    end
    instr_valid = 1'b0;
    chk(done == 1'b1, req, "done after instruction", done, 1);
    m_apply(op, d);
    push_all(req);
    wait (exp_q.size() == 0);
  endtask

  task automatic load_vals(input bit zero_b);
    for (int e = 0; e < N; e++) begin
      ld_a[e*DW +: DW] = va(e);
      ld_b[e*DW +: DW] = zero_b ? 16'h0 : vb(e);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr_op = '0; instr_dir = '0;
    ld_a = '0; ld_b = '0; stream_in = '0;
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) begin
      mp[r][c] = '0; ma[r][c] = '0; mb[r][c] = '0; kp[r][c] = 1; ka[r][c] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    push_all("R1");
    wait (exp_q.size() == 0);

    // R2: parallel load leaves P alone
    load_vals(0);
    issue(4'd1, 3'd0, "R2", 0);
    // R3: add and signed multiply, back to back
    issue(4'd3, 3'd0, "R3", 0);
    issue(4'd4, 3'd0, "R3", 0);
    // R4: accumulate twice
    issue(4'd5, 3'd0, "R4", 0);
    issue(4'd5, 3'd0, "R4", 0);
    // R12: done is a single pulse; unused opcode changes nothing
    chk(done == 1'b1, "R12", "done before idle", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done pulse width", done, 0);
    issue(4'd13, 3'd0, "R12", 0);

    // R5 / R7: shifts in all eight directions, revealed by an add with B = 0
    load_vals(1);
    issue(4'd1, 3'd0, "R2", 0);
    issue(4'd3, 3'd0, "R3", 0);
    for (int d = 0; d < 8; d++) begin
      issue(4'd6, 3'(d), "R5", 0);
      issue(4'd3, 3'd0, "R7", 0);
    end

    // R6: relay of A and of B
    load_vals(0);
    issue(4'd1, 3'd0, "R2", 0);
    issue(4'd7, 3'd5, "R6", 0);
    issue(4'd3, 3'd0, "R6", 0);
    issue(4'd8, 3'd6, "R6", 0);
    issue(4'd3, 3'd0, "R6", 0);
    issue(4'd8, 3'd3, "R6", 0);
    issue(4'd4, 3'd0, "R6", 0);

    // R11: streaming latch into the top row only
    for (int c = 0; c < C; c++) stream_in[c*DW +: DW] = 16'(1000 - c * 333);
    issue(4'd2, 3'd0, "R11", 0);
    issue(4'd3, 3'd0, "R11", 0);

    // R8 / R10: row reduction with an add held valid throughout
    load_vals(0);
    issue(4'd1, 3'd0, "R2", 0);
    issue(4'd3, 3'd0, "R3", 0);
    issue(4'd9, 3'd0, "R8/R10", 1);
    // R9: column reduction gives the grid total in (3,3)
    issue(4'd10, 3'd0, "R9", 0);

    // R9: column reduction on its own
    load_vals(0);
    issue(4'd1, 3'd0, "R2", 0);
    issue(4'd4, 3'd0, "R3", 0);
    issue(4'd10, 3'd0, "R9", 1);

    @(negedge clk);
    summary();
  end

endmodule